// File: doc/BRIEF.md
# Console I/O Port Decoder

This block sits between a home-console processor's 8-bit I/O port space and the peripherals behind it: a programmable sound generator, a video controller (data port, control/status port and its beam counters), the controller-pad latches with their control register, and an optional FM sound unit. Every access is sorted into one of four groups by port bits 7 and 6, and port bit 0 picks the item within the group. The block turns each access into single-cycle strobes and returns read data on a combinational bus. Write data travels to the peripherals directly on the processor's bus, so it is not routed through this block.

A region input chooses between two decode styles for the upper group. In the partial-decode region, any upper port with bit 2 clear reaches the FM unit, and a read there returns the FM data ANDed with the pad data. In the full-decode region, only a few exact addresses respond: two pad-read pairs, one FM pair, and a 2-bit audio output control register. This register drives the PSG and FM mute enables. An FM-present configuration input gates every FM access.

Top module: `console_port_decoder`

## Requirements
- R1: With port bits 7:6 = 01, a write asserts `psg_wr`. With bits 7:6 = 10, a write or read asserts the video data strobe when bit 0 = 0 and the video control strobe when bit 0 = 1. Those reads return `vdata_in` and `vstat_in` respectively.
- R2: A read with port bits 7:6 = 01 returns `vcount_in` when bit 0 = 0 and `hcount_in` when bit 0 = 1, and asserts no read strobe.
- R3: A write with port bits 7:6 = 00 asserts `ioctl_wr` for every such port when `region_full` = 0, and only for ports 0x3E and 0x3F when `region_full` = 1. A read in this group returns 0xFF and asserts no strobe.
- R4: With `region_full` = 1, a read of port 0xC0, 0xC1, 0xDC or 0xDD asserts `pad_rd` and returns `pad_in` only when `pads_off` = 0. Otherwise it returns 0xFF.
- R5: With `region_full` = 1, `fm_wr` is asserted only for writes to ports 0xF0 and 0xF1, and only when `fm_present` = 1. No FM read strobe is ever asserted in this region.
- R6: With `region_full` = 1 and `fm_present` = 1, a write to port 0xF2 loads bits 1:0 of `wr_data` into the audio code. A read of 0xF2 in the full region returns the code in bits 1:0, with bits 7:2 reading zero.
- R7: Audio code 00 sets `psg_en`=1 and `fm_en`=0, code 01 sets 0/1, code 10 sets 0/0, and code 11 sets 1/1. Reset loads code 00. Both outputs are registered and change at the clock edge that ends the write cycle.
- R8: With `region_full` = 0, `fm_present` = 1 and port bits 7:6 = 11, a port with bit 2 = 0 asserts `fm_wr` on a write and `fm_rd` on a read.
- R9: With `region_full` = 0, a read with port bits 7:6 = 11 returns A AND B. A is `fm_in` when `fm_rd` is asserted and 0xFF otherwise. B is `pad_in` when `pads_off` = 0 and 0xFF otherwise. `pad_rd` is asserted exactly when `pads_off` = 0.
- R10: A read of a port that no rule above selects returns 0xFF, and a write to such a port asserts no strobe. A write to 0xF2 with `fm_present` = 0, or in the partial region, leaves `psg_en` and `fm_en` unchanged.
- R11: `reg_sel` equals port bit 0. At most one write strobe is asserted per cycle. Strobes appear only with `wr_en` or `rd_en`. Read strobes are mutually exclusive, except that `fm_rd` and `pad_rd` may be asserted together (R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_addr | input | 8 | I/O port address |
| wr_en | input | 1 | Port write cycle |
| rd_en | input | 1 | Port read cycle |
| wr_data | input | 8 | Write data (only bits 1:0 are used, for the audio code) |
| region_full | input | 1 | 1 selects full decode of the upper group |
| fm_present | input | 1 | FM unit is fitted and enabled |
| pads_off | input | 1 | Pad-read disable bit from the pad control register |
| vcount_in | input | 8 | Vertical beam counter |
| hcount_in | input | 8 | Horizontal beam counter |
| vdata_in | input | 8 | Video data port read value |
| vstat_in | input | 8 | Video status read value |
| pad_in | input | 8 | Controller pad read value |
| fm_in | input | 8 | FM unit read value |
| rd_data | output | 8 | Read data returned to the processor |
| psg_wr | output | 1 | Sound generator write strobe |
| vdata_wr | output | 1 | Video data port write strobe |
| vctrl_wr | output | 1 | Video control port write strobe |
| ioctl_wr | output | 1 | Pad control register write strobe |
| fm_wr | output | 1 | FM unit write strobe |
| vdata_rd | output | 1 | Video data port read strobe |
| vctrl_rd | output | 1 | Video status read strobe |
| pad_rd | output | 1 | Controller pad read strobe |
| fm_rd | output | 1 | FM unit read strobe |
| reg_sel | output | 1 | Sub-address for the selected peripheral (port bit 0) |
| psg_en | output | 1 | Sound generator output enable |
| fm_en | output | 1 | FM output enable |

## Verification
The checker watches every cycle for several conditions. It checks that write strobes are exclusive and that every strobe is qualified by its enable. It checks that a pad read never happens while pads are disabled and that no FM write happens without the unit present. It also checks that the lower group always reads 0xFF, that the sound-generator group always strobes the PSG on a write, and that the mute enables hold except on a full-region upper-group write with FM present. The exact address sets and the ANDed read value need the bench. It sweeps all 256 ports in every region, FM and pad-disable combination, writing and reading each one. Separate bench scenarios cover the audio-code encoding, its reset value, its readback and the writes that must not change it.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

   // Primary group, taken from port bits 7:6
   typedef enum logic [1:0] {
      GRP_PADCTL = 2'b00,
      GRP_SNDHV  = 2'b01,
      GRP_VIDEO  = 2'b10,
      GRP_UPPER  = 2'b11
   } port_grp_e;

   // Exact-address matches used by the full-decode region
   typedef struct packed {
      logic ioctl_hit;
      logic pad_hit;
      logic fm_hit;
      logic audio_hit;
      logic fm_slot;    // partial-region FM slot (select bit clear)
   } port_match_t;

   typedef struct packed {
      logic psg;
      logic vdata;
      logic vctrl;
      logic ioctl;
      logic fm;
      logic audio;
   } wr_sel_t;

   typedef struct packed {
      logic vdata;
      logic vctrl;
      logic pad;
      logic fm;
   } rd_sel_t;

endpackage

// File: rtl/cpd_classify.sv
module cpd_classify
   import cpd_pkg::*;
#(
   parameter int unsigned PORT_W        = 8,
   parameter int unsigned NUM_PAD_PAIRS = 2,
   parameter logic [NUM_PAD_PAIRS*PORT_W-1:0] PAD_BASES = 16'hDCC0,
   parameter logic [PORT_W-1:0] IOCTL_BASE = 8'h3E,
   parameter logic [PORT_W-1:0] FM_BASE    = 8'hF0,
   parameter logic [PORT_W-1:0] AUDIO_PORT = 8'hF2,
   parameter int unsigned FM_SLOT_BIT   = 2
) (
   input  logic [PORT_W-1:0] port_addr,
   output port_grp_e         grp,
   output logic              sub,
   output port_match_t       match
);

   localparam int unsigned PAIR_MSB = PORT_W - 1;

   logic [NUM_PAD_PAIRS-1:0] pad_pair_hit;

   // One comparator per pad-read address pair
   genvar gi;
   generate
      for (gi = 0; gi < NUM_PAD_PAIRS; gi++) begin : g_pad_pair
         localparam logic [PORT_W-1:0] BASE = PAD_BASES[gi*PORT_W +: PORT_W];
         assign pad_pair_hit[gi] = (port_addr[PAIR_MSB:1] == BASE[PAIR_MSB:1]);
      end
   endgenerate

   always_comb begin
      grp             = port_grp_e'(port_addr[PORT_W-1 -: 2]);
      sub             = port_addr[0];
      match.ioctl_hit = (port_addr[PAIR_MSB:1] == IOCTL_BASE[PAIR_MSB:1]);
      match.pad_hit   = |pad_pair_hit;
      match.fm_hit    = (port_addr[PAIR_MSB:1] == FM_BASE[PAIR_MSB:1]);
      match.audio_hit = (port_addr == AUDIO_PORT);
      match.fm_slot   = ~port_addr[FM_SLOT_BIT];
   end

endmodule

// File: rtl/cpd_write_path.sv
module cpd_write_path
   import cpd_pkg::*;
#(
   parameter bit AUDIO_REG_EN = 1'b1
) (
   input  logic        wr_en,
   input  logic        region_full,
   input  logic        fm_present,
   input  port_grp_e   grp,
   input  logic        sub,
   input  port_match_t match,
   output wr_sel_t     sel
);

   always_comb begin
      sel = '0;
      if (wr_en) begin
         unique case (grp)
            GRP_PADCTL: sel.ioctl = ~region_full | match.ioctl_hit;
            GRP_SNDHV:  sel.psg   = 1'b1;
            GRP_VIDEO: begin
               sel.vctrl = sub;
               sel.vdata = ~sub;
            end
            GRP_UPPER: begin
               if (fm_present) begin
                  if (region_full) begin
                     sel.fm    = match.fm_hit;
                     sel.audio = AUDIO_REG_EN & match.audio_hit;
                  end else begin
                     sel.fm    = match.fm_slot;
                  end
               end
            end
            default: sel = '0;
         endcase
      end
   end

endmodule

// File: rtl/cpd_read_path.sv
module cpd_read_path
   import cpd_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter bit          AUDIO_REG_EN = 1'b1
) (
   input  logic              rd_en,
   input  logic              region_full,
   input  logic              fm_present,
   input  logic              pads_off,
   input  port_grp_e         grp,
   input  logic              sub,
   input  port_match_t       match,
   input  logic [1:0]        audio_code,
   input  logic [DATA_W-1:0] vcount_in,
   input  logic [DATA_W-1:0] hcount_in,
   input  logic [DATA_W-1:0] vdata_in,
   input  logic [DATA_W-1:0] vstat_in,
   input  logic [DATA_W-1:0] pad_in,
   input  logic [DATA_W-1:0] fm_in,
   output rd_sel_t           sel,
   output logic [DATA_W-1:0] rd_data
);

   localparam logic [DATA_W-1:0] IDLE_VAL = '1;

   logic [DATA_W-1:0] fm_term;
   logic [DATA_W-1:0] pad_term;
   logic              fm_pick;

   // Partial-region merge: each absent source contributes all ones
   always_comb begin
      fm_pick  = fm_present & match.fm_slot;
      fm_term  = fm_pick  ? fm_in  : IDLE_VAL;
      pad_term = pads_off ? IDLE_VAL : pad_in;
   end

   always_comb begin
      sel     = '0;
      rd_data = IDLE_VAL;
      if (rd_en) begin
         unique case (grp)
            GRP_PADCTL: rd_data = IDLE_VAL;
            GRP_SNDHV:  rd_data = sub ? hcount_in : vcount_in;
            GRP_VIDEO: begin
               sel.vctrl = sub;
               sel.vdata = ~sub;
               rd_data   = sub ? vstat_in : vdata_in;
            end
            GRP_UPPER: begin
               if (region_full) begin
                  if (AUDIO_REG_EN && match.audio_hit) begin
                     rd_data = {{(DATA_W-2){1'b0}}, audio_code};
                  end else if (match.pad_hit && !pads_off) begin
                     sel.pad = 1'b1;
                     rd_data = pad_in;
                  end
               end else begin
                  sel.fm  = fm_pick;
                  sel.pad = ~pads_off;
                  rd_data = fm_term & pad_term;
               end
            end
            default: rd_data = IDLE_VAL;
         endcase
      end
   end

endmodule

// File: rtl/cpd_audio_reg.sv
module cpd_audio_reg #(
   parameter bit AUDIO_REG_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] code_in,
   output logic [1:0] code,
   output logic       psg_en,
   output logic       fm_en
);

   generate
      if (AUDIO_REG_EN) begin : g_reg
         // Enables are registered together with the code they derive from
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code   <= 2'b00;
               psg_en <= 1'b1;
               fm_en  <= 1'b0;
            end else if (load) begin
               code   <= code_in;
               psg_en <= ~(code_in[1] ^ code_in[0]);
               fm_en  <= code_in[0];
            end
         end
      end else begin : g_fixed
         assign code   = 2'b11;
         assign psg_en = 1'b1;
         assign fm_en  = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/console_port_decoder.sv
module console_port_decoder
   import cpd_pkg::*;
#(
   parameter int unsigned PORT_W        = 8,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned NUM_PAD_PAIRS = 2,
   parameter logic [NUM_PAD_PAIRS*PORT_W-1:0] PAD_BASES = 16'hDCC0,
   parameter logic [PORT_W-1:0] IOCTL_BASE = 8'h3E,
   parameter logic [PORT_W-1:0] FM_BASE    = 8'hF0,
   parameter logic [PORT_W-1:0] AUDIO_PORT = 8'hF2,
   parameter int unsigned FM_SLOT_BIT   = 2,
   parameter bit          AUDIO_REG_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              region_full,
   input  logic              fm_present,
   input  logic              pads_off,
   input  logic [DATA_W-1:0] vcount_in,
   input  logic [DATA_W-1:0] hcount_in,
   input  logic [DATA_W-1:0] vdata_in,
   input  logic [DATA_W-1:0] vstat_in,
   input  logic [DATA_W-1:0] pad_in,
   input  logic [DATA_W-1:0] fm_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              psg_wr,
   output logic              vdata_wr,
   output logic              vctrl_wr,
   output logic              ioctl_wr,
   output logic              fm_wr,
   output logic              vdata_rd,
   output logic              vctrl_rd,
   output logic              pad_rd,
   output logic              fm_rd,
   output logic              reg_sel,
   output logic              psg_en,
   output logic              fm_en
);

   // Elaboration-time parameter checks
   generate
      if (PORT_W < 3 || FM_SLOT_BIT < 1 || FM_SLOT_BIT >= PORT_W - 2) begin : g_bad_port
         $error("console_port_decoder: PORT_W/FM_SLOT_BIT out of range");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("console_port_decoder: DATA_W must hold the audio code");
      end
      if (NUM_PAD_PAIRS < 1) begin : g_bad_pads
         $error("console_port_decoder: need at least one pad address pair");
      end
   endgenerate

   port_grp_e   grp;
   logic        sub;
   port_match_t match;
   wr_sel_t     wsel;
   rd_sel_t     rsel;
   logic [1:0]  audio_code;

   cpd_classify #(
      .PORT_W        (PORT_W),
      .NUM_PAD_PAIRS (NUM_PAD_PAIRS),
      .PAD_BASES     (PAD_BASES),
      .IOCTL_BASE    (IOCTL_BASE),
      .FM_BASE       (FM_BASE),
      .AUDIO_PORT    (AUDIO_PORT),
      .FM_SLOT_BIT   (FM_SLOT_BIT)
   ) u_classify (
      .port_addr (port_addr),
      .grp       (grp),
      .sub       (sub),
      .match     (match)
   );

   cpd_write_path #(
      .AUDIO_REG_EN (AUDIO_REG_EN)
   ) u_write (
      .wr_en       (wr_en),
      .region_full (region_full),
      .fm_present  (fm_present),
      .grp         (grp),
      .sub         (sub),
      .match       (match),
      .sel         (wsel)
   );

   cpd_read_path #(
      .DATA_W       (DATA_W),
      .AUDIO_REG_EN (AUDIO_REG_EN)
   ) u_read (
      .rd_en       (rd_en),
      .region_full (region_full),
      .fm_present  (fm_present),
      .pads_off    (pads_off),
      .grp         (grp),
      .sub         (sub),
      .match       (match),
      .audio_code  (audio_code),
      .vcount_in   (vcount_in),
      .hcount_in   (hcount_in),
      .vdata_in    (vdata_in),
      .vstat_in    (vstat_in),
      .pad_in      (pad_in),
      .fm_in       (fm_in),
      .sel         (rsel),
      .rd_data     (rd_data)
   );

   cpd_audio_reg #(
      .AUDIO_REG_EN (AUDIO_REG_EN)
   ) u_audio (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wsel.audio),
      .code_in (wr_data[1:0]),
      .code    (audio_code),
      .psg_en  (psg_en),
      .fm_en   (fm_en)
   );

   assign psg_wr   = wsel.psg;
   assign vdata_wr = wsel.vdata;
   assign vctrl_wr = wsel.vctrl;
   assign ioctl_wr = wsel.ioctl;
   assign fm_wr    = wsel.fm;
   assign vdata_rd = rsel.vdata;
   assign vctrl_rd = rsel.vctrl;
   assign pad_rd   = rsel.pad;
   assign fm_rd    = rsel.fm;
   assign reg_sel  = sub;

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
   parameter int unsigned PORT_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] port_addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic              region_full,
   input logic              fm_present,
   input logic              pads_off,
   input logic [DATA_W-1:0] rd_data,
   input logic              psg_wr,
   input logic              vdata_wr,
   input logic              vctrl_wr,
   input logic              ioctl_wr,
   input logic              fm_wr,
   input logic              vdata_rd,
   input logic              vctrl_rd,
   input logic              pad_rd,
   input logic              fm_rd,
   input logic              psg_en,
   input logic              fm_en
);

   logic [1:0] grp_bits;
   assign grp_bits = port_addr[PORT_W-1 -: 2];

   assert_one_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({psg_wr, vdata_wr, vctrl_wr, ioctl_wr, fm_wr}));

   assert_wr_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (psg_wr | vdata_wr | vctrl_wr | ioctl_wr | fm_wr) |-> wr_en);

   assert_rd_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (vdata_rd | vctrl_rd | pad_rd | fm_rd) |-> rd_en);

   assert_rd_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vdata_rd, vctrl_rd, pad_rd | fm_rd}));

   assert_pad_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pad_rd |-> !pads_off);

   assert_fm_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fm_wr | fm_rd) |-> fm_present);

   assert_no_full_fm_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      region_full |-> !fm_rd);

   assert_lower_unused_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && grp_bits == 2'b00) |-> (rd_data == '1 && !pad_rd && !fm_rd && !vdata_rd && !vctrl_rd));

   assert_psg_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && grp_bits == 2'b01) |-> psg_wr);

   assert_mute_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && region_full && fm_present && grp_bits == 2'b11) |=> $stable({psg_en, fm_en}));

endmodule

bind console_port_decoder cpd_checker u_cpd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .port_addr   (port_addr),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .region_full (region_full),
   .fm_present  (fm_present),
   .pads_off    (pads_off),
   .rd_data     (rd_data),
   .psg_wr      (psg_wr),
   .vdata_wr    (vdata_wr),
   .vctrl_wr    (vctrl_wr),
   .ioctl_wr    (ioctl_wr),
   .fm_wr       (fm_wr),
   .vdata_rd    (vdata_rd),
   .vctrl_rd    (vctrl_rd),
   .pad_rd      (pad_rd),
   .fm_rd       (fm_rd),
   .psg_en      (psg_en),
   .fm_en       (fm_en)
);

// File: tb/console_port_decoder_test.sv
`timescale 1ns/1ps
module console_port_decoder_test;

   localparam logic [7:0] VC_V  = 8'h11;
   localparam logic [7:0] HC_V  = 8'h22;
   localparam logic [7:0] VD_V  = 8'h33;
   localparam logic [7:0] VS_V  = 8'h44;
   localparam logic [7:0] PAD_V = 8'hE7;
   localparam logic [7:0] FM_V  = 8'h7E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] port_addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       region_full = 1'b0, fm_present = 1'b0, pads_off = 1'b0;
   logic [7:0] rd_data;
   logic       psg_wr, vdata_wr, vctrl_wr, ioctl_wr, fm_wr;
   logic       vdata_rd, vctrl_rd, pad_rd, fm_rd, reg_sel, psg_en, fm_en;

   int checks = 0;
   int errors = 0;
   logic [1:0] exp_code = 2'b00;

   always #4 clk = ~clk;   // 125 MHz

   console_port_decoder uut (
      .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .region_full(region_full), .fm_present(fm_present),
      .pads_off(pads_off), .vcount_in(VC_V), .hcount_in(HC_V), .vdata_in(VD_V),
      .vstat_in(VS_V), .pad_in(PAD_V), .fm_in(FM_V), .rd_data(rd_data),
      .psg_wr(psg_wr), .vdata_wr(vdata_wr), .vctrl_wr(vctrl_wr), .ioctl_wr(ioctl_wr),
      .fm_wr(fm_wr), .vdata_rd(vdata_rd), .vctrl_rd(vctrl_rd), .pad_rd(pad_rd),
      .fm_rd(fm_rd), .reg_sel(reg_sel), .psg_en(psg_en), .fm_en(fm_en)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s port=%02h actual=%h expected=%h", req, port_addr, act, exp);
      end
   endtask

   // Expected write strobes {psg,vdata,vctrl,ioctl,fm}, from R1 R3 R5 R8 R10
   function automatic logic [4:0] ref_wr(input logic [7:0] p, input logic full, input logic fm);
      logic [4:0] s = '0;
      case (p[7:6])
         2'b00: s[1] = !full || p == 8'h3E || p == 8'h3F;
         2'b01: s[4] = 1'b1;
         2'b10: if (p[0]) s[2] = 1'b1; else s[3] = 1'b1;
         default: if (fm) s[0] = full ? (p == 8'hF0 || p == 8'hF1) : !p[2];
      endcase
      return s;
   endfunction

   // Expected {data, vdata_rd, vctrl_rd, pad_rd, fm_rd}, from R1 R2 R3 R4 R6 R9 R10
   function automatic logic [11:0] ref_rd(input logic [7:0] p, input logic full,
                                          input logic fm, input logic poff, input logic [1:0] code);
      logic [7:0] d = 8'hFF;
      logic [3:0] s = '0;
      logic [7:0] a, b;
      case (p[7:6])
         2'b00: d = 8'hFF;
         2'b01: d = p[0] ? HC_V : VC_V;
         2'b10: begin d = p[0] ? VS_V : VD_V; if (p[0]) s[2] = 1'b1; else s[3] = 1'b1; end
         default: begin
            if (full) begin
               if (p == 8'hF2) d = {6'b0, code};
               else if ((p == 8'hC0 || p == 8'hC1 || p == 8'hDC || p == 8'hDD) && !poff) begin
                  d = PAD_V; s[1] = 1'b1;
               end
            end else begin
               a = (fm && !p[2]) ? FM_V : 8'hFF;
               b = poff ? 8'hFF : PAD_V;
               d = a & b;
               s[0] = fm && !p[2];
               s[1] = !poff;
            end
         end
      endcase
      return {d, s};
   endfunction

   task automatic drive(input logic [7:0] p, input logic w, input logic r, input logic [7:0] d);
      @(negedge clk);
      port_addr = p; wr_en = w; rd_en = r; wr_data = d;
      #2;
   endtask

   function automatic logic [1:0] ref_mute(input logic [1:0] c);
      case (c)
         2'b00: return 2'b10;
         2'b01: return 2'b01;
         2'b10: return 2'b00;
         default: return 2'b11;
      endcase
   endfunction

   task automatic test_reset();
      drive(8'h00, 1'b0, 1'b0, 8'h00);
      check("R7 reset psg_en/fm_en", {14'b0, psg_en, fm_en}, 16'h0002);
      check("R11 idle strobes", {7'b0, psg_wr, vdata_wr, vctrl_wr, ioctl_wr, fm_wr,
            vdata_rd, vctrl_rd, pad_rd, fm_rd}, 16'h0000);
   endtask

   // Every port, written then read, in one region/FM/pad setting
   task automatic test_sweep(input logic full, input logic fm, input logic poff);
      region_full = full; fm_present = fm; pads_off = poff;
      for (int i = 0; i < 256; i++) begin
         logic [7:0] p = 8'(i);
         drive(p, 1'b1, 1'b0, {6'b0, exp_code});
         check("R1 R3 R5 R8 R10 write strobes",
               {11'b0, psg_wr, vdata_wr, vctrl_wr, ioctl_wr, fm_wr}, {11'b0, ref_wr(p, full, fm)});
         check("R11 reg_sel / no read strobe on write",
               {11'b0, reg_sel, vdata_rd, vctrl_rd, pad_rd, fm_rd}, {11'b0, p[0], 4'b0});
         drive(p, 1'b0, 1'b1, 8'h00);
         check("R1 R2 R3 R4 R6 R9 R10 read",
               {4'b0, rd_data, vdata_rd, vctrl_rd, pad_rd, fm_rd},
               {4'b0, ref_rd(p, full, fm, poff, exp_code)});
         check("R11 no write strobe on read",
               {11'b0, psg_wr, vdata_wr, vctrl_wr, ioctl_wr, fm_wr}, 16'h0000);
      end
      drive(8'h00, 1'b0, 1'b0, 8'h00);
      check("R10 mute enables kept by sweep", {14'b0, psg_en, fm_en}, {14'b0, ref_mute(exp_code)});
   endtask

   task automatic test_audio_codes();
      region_full = 1'b1; fm_present = 1'b1; pads_off = 1'b0;
      for (int c = 0; c < 4; c++) begin
         drive(8'hF2, 1'b1, 1'b0, {6'b101010, 2'(c)});
         check("R7 enables unchanged during write cycle", {14'b0, psg_en, fm_en},
               {14'b0, ref_mute(exp_code)});
         exp_code = 2'(c);
         drive(8'hF2, 1'b0, 1'b1, 8'h00);
         check("R7 mute enables after write", {14'b0, psg_en, fm_en}, {14'b0, ref_mute(exp_code)});
         check("R6 audio code readback", {8'b0, rd_data}, {14'b0, exp_code});
      end
   endtask

   task automatic test_audio_ignored();
      region_full = 1'b1; fm_present = 1'b0;
      drive(8'hF2, 1'b1, 1'b0, 8'h00);
      drive(8'hF2, 1'b0, 1'b1, 8'h00);
      check("R10 no-FM write to 0xF2 ignored", {14'b0, psg_en, fm_en}, {14'b0, ref_mute(exp_code)});
      check("R6 readback without FM", {8'b0, rd_data}, {14'b0, exp_code});
      region_full = 1'b0; fm_present = 1'b1;
      drive(8'hF2, 1'b1, 1'b0, 8'h01);
      check("R8 partial 0xF2 write goes to FM", {15'b0, fm_wr}, 16'h0001);
      drive(8'h00, 1'b0, 1'b0, 8'h00);
      check("R10 partial write to 0xF2 leaves mute", {14'b0, psg_en, fm_en}, {14'b0, ref_mute(exp_code)});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      test_reset();
      for (int k = 0; k < 8; k++) test_sweep(k[2], k[1], k[0]);
      test_audio_codes();
      test_audio_ignored();
      region_full = 1'b1; fm_present = 1'b1; exp_code = 2'b00;
      test_sweep(1'b1, 1'b1, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule